// File: doc/BRIEF.md
# Video Measurement Window Masker

This block marks which pixel samples of a video stream may be used by an image-quality measurement engine. Every pixel clock it looks at the horizontal sync, the vertical sync and a pixel-valid strobe. It raises a single qualifier when the current sample lies inside a programmable window. The window leaves out pixels next to each horizontal sync edge and lines next to each vertical sync edge, on both sides of the edge.

Blanking on the far side of an edge means the block has to know where the next edge will fall. It measures the length of each line in clock cycles and the height of each frame in lines, and uses the last measured values as the prediction for the period that follows. Two 3-bit codes choose the vertical margins from fixed tables of common line counts. Two 8-bit counts set the horizontal margins in steps of two pixels.

Top module: `vid_win_mask`

## Requirements
- R1: While reset is asserted and afterwards, `winValid` stays 0 until two rising edges of `hsync` and two rising edges of `vsync` have been seen after reset. Only then is one full line and one full frame measured.
- R2: `winValid` is registered. It reflects the sample presented in the previous clock cycle and is 1 only if `pixValid` was 1 in that cycle.
- R3: A rising edge of `hsync` is a cycle with `hsync` high after a cycle with it low. That cycle is horizontal position 0, and each later cycle adds one. Positions 0 to 2*`hPostCnt`-1 are excluded.
- R4: Let L be the number of cycles between the two most recent `hsync` rising edges. Positions p with p + 2*`hPreCnt` >= L are excluded, so the last 2*`hPreCnt` cycles before the next edge are blanked.
- R5: A rising edge of `vsync` makes the current line line 0, and each later `hsync` rising edge adds one. Lines below a count chosen by `vPostCode` are excluded: code 0..7 gives 5, 18, 19, 20, 22, 25, 41, 44 lines.
- R6: Let F be the number of lines in the previous frame. Lines v with v + K >= F are excluded, where K comes from `vPreCode`: code 0..7 gives 0, 1, 2, 4, 6, 8, 10, 12 lines.
- R7: When `hsync` and `vsync` rise in the same cycle, the line counter restarts at line 0 and does not advance. That cycle is line 0, position 0.
- R8: A sample is inside the window only when it passes both the horizontal and the vertical test. Settings whose horizontal or vertical margins cover the whole period give an empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync, active high; the rising edge counts |
| vsync | input | 1 | Vertical sync, active high; the rising edge counts |
| pixValid | input | 1 | Sample in this cycle is valid |
| vPreCode | input | 3 | Code for the lines excluded before the vertical edge |
| vPostCode | input | 3 | Code for the lines excluded after the vertical edge |
| hPostCnt | input | 8 | Half the number of pixels excluded after the horizontal edge (must be above 0) |
| hPreCnt | input | 8 | Half the number of pixels excluded before the horizontal edge (must be above 0) |
| winValid | output | 1 | Window qualifier, one cycle after its sample |

## Verification
The horizontal restart and the vertical restart land in the same cycle at the top of every frame. The bench makes the `vsync` rise coincide with an `hsync` rise and holds both pulses high for several cycles or lines, so only the edges count. The bench computes the window independently from the line and position indices it generates. It judges the first line after the coincident edge as line 0 at position 0, against the post-edge margins. It also judges the last line before the edge against the pre-edge margin, taken from the previous frame's height.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  typedef struct packed {
    logic hsEdge;
    logic vsEdge;
    logic measured;
  } vwm_strobe_t;
endpackage

// File: rtl/vwm_ctrl.sv
module vwm_ctrl
  import vwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hsync,
  input  logic        vsync,
  output vwm_strobe_t strobes
);
  logic hsPrev, vsPrev;
  logic [1:0] hsCnt, vsCnt;
  logic hsEdge, vsEdge;

  assign hsEdge = hsync & ~hsPrev;
  assign vsEdge = vsync & ~vsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrev <= 1'b0;
      vsPrev <= 1'b0;
      hsCnt  <= '0;
      vsCnt  <= '0;
    end else begin
      hsPrev <= hsync;
      vsPrev <= vsync;
      if (hsEdge && !hsCnt[1]) hsCnt <= hsCnt + 2'd1;
      if (vsEdge && !vsCnt[1]) vsCnt <= vsCnt + 2'd1;
    end
  end

  assign strobes.hsEdge   = hsEdge;
  assign strobes.vsEdge   = vsEdge;
  assign strobes.measured = hsCnt[1] & vsCnt[1];
endmodule

// File: rtl/vwm_dpath.sv
module vwm_dpath
  import vwm_pkg::*;
#(
  parameter int HPOS_W = 12,
  parameter int VPOS_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  vwm_strobe_t strobes,
  input  logic        pixValid,
  input  logic [2:0]  vPreCode,
  input  logic [2:0]  vPostCode,
  input  logic [7:0]  hPostCnt,
  input  logic [7:0]  hPreCnt,
  output logic        winValid
);
  localparam int HW1 = HPOS_W + 1;
  localparam int VW1 = VPOS_W + 1;
  localparam logic [HPOS_W-1:0] HMAX = {HPOS_W{1'b1}};
  localparam logic [VPOS_W-1:0] VMAX = {VPOS_W{1'b1}};

  logic [HPOS_W-1:0] hPosQ, lineLenQ, curH, hNext;
  logic [VPOS_W-1:0] vPosQ, frameLenQ, curV, vNext;
  logic [5:0] postLines;
  logic [3:0] preLines;
  logic hIn, vIn;

  // line counts picked by the vertical codes
  always_comb begin
    unique case (vPostCode)
      3'd0: postLines = 6'd5;
      3'd1: postLines = 6'd18;
      3'd2: postLines = 6'd19;
      3'd3: postLines = 6'd20;
      3'd4: postLines = 6'd22;
      3'd5: postLines = 6'd25;
      3'd6: postLines = 6'd41;
      default: postLines = 6'd44;
    endcase
    if (vPreCode <= 3'd2) preLines = {1'b0, vPreCode};
    else                  preLines = {({1'b0, vPreCode} - 4'd1), 1'b0} ;
  end

  assign hNext = (hPosQ == HMAX) ? HMAX : hPosQ + 1'b1;
  assign vNext = (vPosQ == VMAX) ? VMAX : vPosQ + 1'b1;
  assign curH  = strobes.hsEdge ? '0 : hNext;
  assign curV  = strobes.vsEdge ? '0 : (strobes.hsEdge ? vNext : vPosQ);

  assign hIn = ({1'b0, curH} >= HW1'({hPostCnt, 1'b0})) &&
               (({1'b0, curH} + HW1'({hPreCnt, 1'b0})) < {1'b0, lineLenQ});
  assign vIn = ({1'b0, curV} >= VW1'(postLines)) &&
               (({1'b0, curV} + VW1'(preLines)) < {1'b0, frameLenQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPosQ     <= '0;
      vPosQ     <= '0;
      lineLenQ  <= '0;
      frameLenQ <= '0;
      winValid  <= 1'b0;
    end else begin
      hPosQ <= curH;
      vPosQ <= curV;
      if (strobes.hsEdge) lineLenQ  <= hNext;
      if (strobes.vsEdge) frameLenQ <= vNext;
      winValid <= pixValid & strobes.measured & hIn & vIn;
    end
  end
endmodule

// File: rtl/vid_win_mask.sv
module vid_win_mask
  import vwm_pkg::*;
#(
  parameter int HPOS_W = 12,
  parameter int VPOS_W = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       pixValid,
  input  logic [2:0] vPreCode,
  input  logic [2:0] vPostCode,
  input  logic [7:0] hPostCnt,
  input  logic [7:0] hPreCnt,
  output logic       winValid
);
  vwm_strobe_t strobes;

  vwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync), .strobes(strobes)
  );

  vwm_dpath #(.HPOS_W(HPOS_W), .VPOS_W(VPOS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pixValid(pixValid),
    .vPreCode(vPreCode), .vPostCode(vPostCode),
    .hPostCnt(hPostCnt), .hPreCnt(hPreCnt), .winValid(winValid)
  );
endmodule

// File: rtl/vid_win_mask_chk.sv
module vid_win_mask_chk (
  input logic clk,
  input logic rstN,
  input logic hsync,
  input logic vsync,
  input logic pixValid,
  input logic measured,
  input logic winValid
);
  // R1: output held low in reset
  a_r1_reset_low: assert property (@(posedge clk) !rstN |=> !winValid);

  // R1: nothing passes before geometry is learned
  a_r1_unmeasured: assert property (@(posedge clk) disable iff (!rstN)
    !measured |=> !winValid);

  // R2: qualifier follows a valid sample by one cycle
  a_r2_needs_pixvalid: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> $past(pixValid));

  // R3: at least two samples after the horizontal edge are blanked
  a_r3_hs_edge_blanks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsync) |=> !winValid ##1 !winValid);

  // R5: the vertical edge line is always blanked
  a_r5_vs_edge_blanks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |=> !winValid);
endmodule

bind vid_win_mask vid_win_mask_chk u_chk (
  .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync),
  .pixValid(pixValid), .measured(strobes.measured), .winValid(winValid)
);

// File: tb/vid_win_mask_bench.sv
module vid_win_mask_bench;
  logic clk = 1'b0;
  logic rstN, hsync, vsync, pixValid, winValid;
  logic [2:0] vPreCode, vPostCode;
  logic [7:0] hPostCnt, hPreCnt;

  always #10 clk = ~clk;

  vid_win_mask u_vid_win_mask (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync), .pixValid(pixValid),
    .vPreCode(vPreCode), .vPostCode(vPostCode), .hPostCnt(hPostCnt),
    .hPreCnt(hPreCnt), .winValid(winValid)
  );

  int checks = 0, failures = 0;
  int preTbl[8]  = '{0, 1, 2, 4, 6, 8, 10, 12};
  int postTbl[8] = '{5, 18, 19, 20, 22, 25, 41, 44};
  int lineLen, frameLen, hEdges, vEdges;
  bit expPrev, havePrev;
  string tagPrev;

  task automatic check(bit exp, string tag);
    checks++;
    if (winValid !== exp) begin
      failures++;
      $display("FAIL %s winValid=%0b expected=%0b", tag, winValid, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; hsync = 0; vsync = 0; pixValid = 0;
    havePrev = 0; hEdges = 0; vEdges = 0;
    repeat (3) begin @(negedge clk); check(1'b0, "R1 reset"); end
    rstN = 1'b1;
    @(negedge clk); check(1'b0, "R1 idle after reset");
  endtask

  task automatic runFrames(int nFrames, int cPre, int cPost, int cHp, int cHr);
    for (int f = 0; f < nFrames; f++)
      for (int v = 0; v < frameLen; v++)
        for (int h = 0; h < lineLen; h++) begin
          bit pv, known, hIn, vIn;
          @(negedge clk);
          if (havePrev) check(expPrev, tagPrev);
          vPreCode = 3'(cPre); vPostCode = 3'(cPost);
          hPostCnt = 8'(cHp);  hPreCnt = 8'(cHr);
          hsync = (h < 3);
          vsync = (v < 3);
          pv = ((h * 7 + v * 3 + f) % 5) != 0;
          pixValid = pv;
          if (h == 0) hEdges++;
          if (h == 0 && v == 0) vEdges++;
          known = (hEdges >= 2) && (vEdges >= 2);
          hIn = (h >= 2 * cHp) && (h + 2 * cHr < lineLen);
          vIn = (v >= postTbl[cPost]) && (v + preTbl[cPre] < frameLen);
          expPrev = pv && known && hIn && vIn;
          if (!known)                        tagPrev = "R1 unmeasured";
          else if (h == 0 && v == 0)         tagPrev = "R7 coincident edges";
          else if (h < 2 * cHp)              tagPrev = "R3 post-hsync";
          else if (h + 2 * cHr >= lineLen)   tagPrev = "R4 pre-hsync";
          else if (v < postTbl[cPost])       tagPrev = "R5 post-vsync";
          else if (v + preTbl[cPre] >= frameLen) tagPrev = "R6 pre-vsync";
          else if (!pv)                      tagPrev = "R2 pixValid gating";
          else                               tagPrev = "R8 window interior";
          havePrev = 1;
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vPreCode = 3'd1; vPostCode = 3'd0; hPostCnt = 8'd1; hPreCnt = 8'd1;
    lineLen = 40; frameLen = 64;
    doReset();
    runFrames(1, 1, 0, 1, 1);
    for (int i = 0; i < 8; i++) runFrames(2, i, 7 - i, 1 + i, 8 - i);
    runFrames(1, 3, 2, 15, 6);   // R8 horizontal margins overlap: empty
    lineLen = 24; frameLen = 50;
    doReset();
    runFrames(2, 0, 0, 1, 1);
    runFrames(1, 7, 7, 2, 3);    // R8 vertical margins overlap: empty
    runFrames(1, 5, 3, 4, 2);
    @(negedge clk);
    if (havePrev) check(expPrev, tagPrev);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule